// File: doc/BRIEF.md
# Segment Access and Privileged Instruction Guard

This block judges, one cycle at a time, whether the operand access and the instruction presented to it are allowed. An access is described by its kind (read, write or fetch), the attributes of the segment it targets, the segment limit, a 16-bit offset and the access span. An instruction is described by a decoded class, the current privilege level (CPL) and the old flags word, which carries the I/O privilege level (IOPL). A violation sets a fault flag together with the exception vector to raise.

The same block filters the flags word written back by interrupt-return and flag-pop operations. When the caller lacks the privilege to change a protected bit, that bit keeps its old value. This is done silently, without a fault. All results are registered and appear on the clock edge after the inputs are sampled.

Top module: `prot_check_unit`

## Requirements
- R1: A write (`acc_kind`=1) to a code segment (`seg_code`=1) gives `fault`=1 and `fault_vec`=13.
- R2: A read (`acc_kind`=0) of a code segment whose readable bit `seg_rw` is 0 (execute-only) gives vector 13. A read of a readable code segment passes the type check. A fetch (`acc_kind`=2) from a data segment (`seg_code`=0) gives vector 13, and a fetch from any code segment passes the type check.
- R3: A write to a data segment whose writable bit `seg_rw` is 0 gives vector 13.
- R4: The last byte is `acc_ofs + acc_span`, where `acc_span` is the span in bytes minus one. If that last byte is above `seg_limit`, the block faults with vector 12 when `seg_stack`=1 and vector 13 otherwise. When a type violation and a limit violation occur together, vector 13 wins.
- R5: The last-byte sum is taken modulo 2^16 and its carry is dropped. So offset 0xFFFF with span 1 ends at 0x0000.
- R6: Instruction class 1 (system control) faults with vector 13 unless CPL is 0.
- R7: Instruction class 2 (I/O, interrupt enable/disable, bus lock) faults with vector 13 when CPL is numerically greater than IOPL. IOPL is taken from bits 14:13 of `flags_cur`. Classes 0 and 3 never fault.
- R8: On a flag update, bit 9 (interrupt enable) of `flags_out` keeps the old `flags_cur` value when CPL > IOPL. Otherwise it takes the new value.
- R9: On a flag update, bits 14:13 keep the old value unless CPL is 0. All other bits take the new value. A flag update never causes a fault.
- R10: Outputs change one cycle after the inputs are sampled. Without a valid access or a faulting instruction, `fault` is 0 and `fault_vec` is 0. `flags_wr` equals the previous cycle's `flag_upd`.
- R11: When an instruction fault and an access fault occur in the same cycle, the vector is 13.
- R12: After reset, `fault`, `fault_vec`, `flags_out` and `flags_wr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Operand access present |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 idle |
| seg_code | input | 1 | Segment is code (1) or data (0) |
| seg_rw | input | 1 | Code: readable; data: writable |
| seg_stack | input | 1 | Access goes through the stack segment |
| seg_limit | input | 16 | Highest valid offset |
| acc_ofs | input | 16 | Access offset |
| acc_span | input | 2 | Access size in bytes minus one |
| ins_valid | input | 1 | Decoded instruction present |
| ins_class | input | 2 | 0 plain, 1 system, 2 I/O-gated, 3 plain |
| cpl | input | 2 | Current privilege level |
| flags_cur | input | 16 | Current flags word |
| flag_upd | input | 1 | Interrupt-return or flag-pop write request |
| flags_new | input | 16 | Flags value proposed by the operation |
| fault | output | 1 | Violation detected |
| fault_vec | output | 8 | Exception vector, 0 when no fault |
| flags_out | output | 16 | Filtered flags word |
| flags_wr | output | 1 | `flags_out` is valid this cycle |

## Verification
The block keeps no state apart from its output registers. A wrong decision therefore shows at the ports on the edge right after the stimulus and is gone one cycle later. A wrong type or limit decode appears as a missing or extra `fault`, or as 12 where 13 is due. A wrong flag mask appears as a bit 9 or bits 14:13 of `flags_out` that differ from what CPL and IOPL allow. The bench checks every cycle against its own model, so a single-cycle slip or a mask on the wrong bit is caught on the first affected vector.

// File: rtl/prot_pkg.sv
package prot_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_IDLE  = 2'd3
  } acc_kind_t;

  typedef enum logic [1:0] {
    CLS_PLAIN = 2'd0,
    CLS_SYS   = 2'd1,
    CLS_IO    = 2'd2,
    CLS_RSVD  = 2'd3
  } ins_cls_t;

  localparam logic [7:0] VEC_NONE  = 8'd0;
  localparam logic [7:0] VEC_STACK = 8'd12;
  localparam logic [7:0] VEC_GP    = 8'd13;
endpackage

// File: rtl/prot_seg_check.sv
module prot_seg_check import prot_pkg::*; #(
  parameter int OFS_W  = 16,
  parameter int SPAN_W = 2
) (
  input  acc_kind_t          kind,
  input  logic               is_code,
  input  logic               rw,
  input  logic [OFS_W-1:0]   limit,
  input  logic [OFS_W-1:0]   offset,
  input  logic [SPAN_W-1:0]  span,
  output logic               type_err,
  output logic               lim_err
);
  logic [OFS_W-1:0] last_byte;

  // carry out of the offset sum is dropped on purpose
  assign last_byte = offset + OFS_W'(span);
  assign lim_err   = (kind != ACC_IDLE) && (last_byte > limit);

  always_comb begin
    unique case (kind)
      ACC_READ:  type_err = is_code && !rw;
      ACC_WRITE: type_err = is_code || !rw;
      ACC_FETCH: type_err = !is_code;
      default:   type_err = 1'b0;
    endcase
  end
endmodule

// File: rtl/prot_priv_check.sv
module prot_priv_check import prot_pkg::*; #(
  parameter int PL_W = 2
) (
  input  ins_cls_t          cls,
  input  logic [PL_W-1:0]   cpl,
  input  logic [PL_W-1:0]   iopl,
  output logic              priv_err
);
  always_comb begin
    unique case (cls)
      CLS_SYS: priv_err = (cpl != '0);
      CLS_IO:  priv_err = (cpl > iopl);
      default: priv_err = 1'b0;
    endcase
  end
endmodule

// File: rtl/prot_flag_filter.sv
module prot_flag_filter #(
  parameter int FLAG_W  = 16,
  parameter int PL_W    = 2,
  parameter int IE_BIT  = 9,
  parameter int IOPL_LO = 13
) (
  input  logic [FLAG_W-1:0] old_flags,
  input  logic [FLAG_W-1:0] new_flags,
  input  logic [PL_W-1:0]   cpl,
  output logic [FLAG_W-1:0] kept_flags
);
  localparam int IOPL_HI = IOPL_LO + PL_W - 1;

  logic [PL_W-1:0] iopl;
  assign iopl = old_flags[IOPL_HI:IOPL_LO];

  always_comb begin
    kept_flags = new_flags;
    if (cpl > iopl)
      kept_flags[IE_BIT] = old_flags[IE_BIT];
    if (cpl != '0)
      kept_flags[IOPL_HI:IOPL_LO] = old_flags[IOPL_HI:IOPL_LO];
  end
endmodule

// File: rtl/prot_check_unit.sv
module prot_check_unit import prot_pkg::*; #(
  parameter int OFS_W   = 16,
  parameter int SPAN_W  = 2,
  parameter int FLAG_W  = 16,
  parameter int PL_W    = 2,
  parameter int IE_BIT  = 9,
  parameter int IOPL_LO = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [1:0]        acc_kind,
  input  logic              seg_code,
  input  logic              seg_rw,
  input  logic              seg_stack,
  input  logic [OFS_W-1:0]  seg_limit,
  input  logic [OFS_W-1:0]  acc_ofs,
  input  logic [SPAN_W-1:0] acc_span,
  input  logic              ins_valid,
  input  logic [1:0]        ins_class,
  input  logic [PL_W-1:0]   cpl,
  input  logic [FLAG_W-1:0] flags_cur,
  input  logic              flag_upd,
  input  logic [FLAG_W-1:0] flags_new,
  output logic              fault,
  output logic [7:0]        fault_vec,
  output logic [FLAG_W-1:0] flags_out,
  output logic              flags_wr
);
  localparam int IOPL_HI = IOPL_LO + PL_W - 1;

  logic              type_err, lim_err, priv_err;
  logic [7:0]        vec_d;
  logic [FLAG_W-1:0] kept_flags;

  prot_seg_check #(.OFS_W(OFS_W), .SPAN_W(SPAN_W)) u_seg (
    .kind     (acc_kind_t'(acc_kind)),
    .is_code  (seg_code),
    .rw       (seg_rw),
    .limit    (seg_limit),
    .offset   (acc_ofs),
    .span     (acc_span),
    .type_err (type_err),
    .lim_err  (lim_err)
  );

  prot_priv_check #(.PL_W(PL_W)) u_priv (
    .cls      (ins_cls_t'(ins_class)),
    .cpl      (cpl),
    .iopl     (flags_cur[IOPL_HI:IOPL_LO]),
    .priv_err (priv_err)
  );

  prot_flag_filter #(
    .FLAG_W(FLAG_W), .PL_W(PL_W), .IE_BIT(IE_BIT), .IOPL_LO(IOPL_LO)
  ) u_flags (
    .old_flags  (flags_cur),
    .new_flags  (flags_new),
    .cpl        (cpl),
    .kept_flags (kept_flags)
  );

  // instruction faults first, then segment type, then limit
  always_comb begin
    vec_d = VEC_NONE;
    if (ins_valid && priv_err)
      vec_d = VEC_GP;
    else if (acc_valid && type_err)
      vec_d = VEC_GP;
    else if (acc_valid && lim_err)
      vec_d = seg_stack ? VEC_STACK : VEC_GP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fault     <= 1'b0;
      fault_vec <= VEC_NONE;
      flags_out <= '0;
      flags_wr  <= 1'b0;
    end else begin
      fault     <= (vec_d != VEC_NONE);
      fault_vec <= vec_d;
      flags_wr  <= flag_upd;
      if (flag_upd)
        flags_out <= kept_flags;
    end
  end
endmodule

// File: rtl/prot_check_sva.sv
module prot_check_sva #(
  parameter int OFS_W   = 16,
  parameter int FLAG_W  = 16,
  parameter int PL_W    = 2,
  parameter int IE_BIT  = 9,
  parameter int IOPL_LO = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_valid,
  input logic [1:0]        acc_kind,
  input logic              seg_code,
  input logic [1:0]        ins_class,
  input logic              ins_valid,
  input logic [PL_W-1:0]   cpl,
  input logic [FLAG_W-1:0] flags_cur,
  input logic              flag_upd,
  input logic              fault,
  input logic [7:0]        fault_vec,
  input logic [FLAG_W-1:0] flags_out,
  input logic              flags_wr
);
  localparam int IOPL_HI = IOPL_LO + PL_W - 1;

  p_write_code_r1: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_kind == 2'd1 && seg_code) |=> (fault && fault_vec == 8'd13));

  p_sys_priv_r6: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && ins_class == 2'd1 && cpl != '0) |=> (fault && fault_vec == 8'd13));

  p_io_priv_r7: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && ins_class == 2'd2 && cpl > flags_cur[IOPL_HI:IOPL_LO])
      |=> (fault && fault_vec == 8'd13));

  p_ie_kept_r8: assert property (@(posedge clk) disable iff (rst)
    (flag_upd && cpl > flags_cur[IOPL_HI:IOPL_LO])
      |=> (flags_out[IE_BIT] == $past(flags_cur[IE_BIT])));

  p_iopl_kept_r9: assert property (@(posedge clk) disable iff (rst)
    (flag_upd && cpl != '0)
      |=> (flags_out[IOPL_HI:IOPL_LO] == $past(flags_cur[IOPL_HI:IOPL_LO])));

  p_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (!acc_valid && !ins_valid) |=> (!fault && fault_vec == 8'd0));

  p_wr_follow_r10: assert property (@(posedge clk) disable iff (rst)
    flag_upd |=> flags_wr);

  p_vec_range_r4: assert property (@(posedge clk) disable iff (rst)
    fault |-> (fault_vec == 8'd12 || fault_vec == 8'd13));

  p_no_vec_r10: assert property (@(posedge clk) disable iff (rst)
    !fault |-> fault_vec == 8'd0);
endmodule

bind prot_check_unit prot_check_sva #(
  .OFS_W(OFS_W), .FLAG_W(FLAG_W), .PL_W(PL_W), .IE_BIT(IE_BIT), .IOPL_LO(IOPL_LO)
) u_sva (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_kind(acc_kind),
  .seg_code(seg_code), .ins_class(ins_class), .ins_valid(ins_valid),
  .cpl(cpl), .flags_cur(flags_cur), .flag_upd(flag_upd), .fault(fault),
  .fault_vec(fault_vec), .flags_out(flags_out), .flags_wr(flags_wr)
);

// File: tb/test_prot_check_unit.sv
`timescale 1ns/1ps
module test_prot_check_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        acc_valid, seg_code, seg_rw, seg_stack, ins_valid, flag_upd;
  logic [1:0]  acc_kind, acc_span, ins_class, cpl;
  logic [15:0] seg_limit, acc_ofs, flags_cur, flags_new;
  logic        fault, flags_wr;
  logic [7:0]  fault_vec;
  logic [15:0] flags_out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  prot_check_unit i_prot_check_unit (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_kind(acc_kind),
    .seg_code(seg_code), .seg_rw(seg_rw), .seg_stack(seg_stack),
    .seg_limit(seg_limit), .acc_ofs(acc_ofs), .acc_span(acc_span),
    .ins_valid(ins_valid), .ins_class(ins_class), .cpl(cpl),
    .flags_cur(flags_cur), .flag_upd(flag_upd), .flags_new(flags_new),
    .fault(fault), .fault_vec(fault_vec), .flags_out(flags_out),
    .flags_wr(flags_wr)
  );

  // expected vector and the requirement that decides it
  function automatic logic [7:0] ref_vec(output string tag);
    logic [15:0] last;
    logic [1:0]  iopl;
    logic        t_err;
    iopl = flags_cur[14:13];
    last = acc_ofs + {14'd0, acc_span};
    tag  = "R10";
    if (ins_valid && ins_class == 2'd1 && cpl != 2'd0) begin
      tag = "R6"; return 8'd13;
    end
    if (ins_valid && ins_class == 2'd2 && cpl > iopl) begin
      tag = "R7"; return 8'd13;
    end
    if (!acc_valid || acc_kind == 2'd3) return 8'd0;
    t_err = 1'b0;
    case (acc_kind)
      2'd0: begin t_err = seg_code && !seg_rw; tag = "R2"; end
      2'd1: begin t_err = seg_code || !seg_rw; tag = seg_code ? "R1" : "R3"; end
      default: begin t_err = !seg_code; tag = "R2"; end
    endcase
    if (t_err) return 8'd13;
    tag = "R4";
    if (last > seg_limit) return seg_stack ? 8'd12 : 8'd13;
    return 8'd0;
  endfunction

  function automatic logic [15:0] ref_flags(output string tag);
    logic [15:0] r;
    r = flags_new;
    tag = "R9";
    if (cpl > flags_cur[14:13]) begin r[9] = flags_cur[9]; tag = "R8"; end
    if (cpl != 2'd0) r[14:13] = flags_cur[14:13];
    return r;
  endfunction

  task automatic idle_inputs();
    acc_valid = 0; acc_kind = 2'd3; seg_code = 0; seg_rw = 0; seg_stack = 0;
    seg_limit = 16'hFFFF; acc_ofs = 0; acc_span = 0; ins_valid = 0;
    ins_class = 0; cpl = 0; flags_cur = 0; flag_upd = 0; flags_new = 0;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // inputs are set on a falling edge; outputs checked on the next falling edge
  task automatic step_and_check();
    string       vt, ft;
    logic [7:0]  ev;
    logic [15:0] ef;
    logic        upd;
    ev  = ref_vec(vt);
    ef  = ref_flags(ft);
    upd = flag_upd;
    @(negedge clk);
    chk(vt, {31'd0, fault}, {31'd0, ev != 8'd0});
    chk(vt, {24'd0, fault_vec}, {24'd0, ev});
    chk("R10", {31'd0, flags_wr}, {31'd0, upd});
    if (upd) chk(ft, {16'd0, flags_out}, {16'd0, ef});
  endtask

  task automatic access(input logic [1:0] k, input logic code, input logic rw,
                        input logic stk, input logic [15:0] lim,
                        input logic [15:0] ofs, input logic [1:0] span);
    idle_inputs();
    acc_valid = 1; acc_kind = k; seg_code = code; seg_rw = rw; seg_stack = stk;
    seg_limit = lim; acc_ofs = ofs; acc_span = span;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    idle_inputs();
    rst = 1;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12", {31'd0, fault}, 32'd0);
    chk("R12", {24'd0, fault_vec}, 32'd0);
    chk("R12", {16'd0, flags_out}, 32'd0);
    chk("R12", {31'd0, flags_wr}, 32'd0);
    rst = 0;

    // R1 write into code
    access(2'd1, 1, 1, 0, 16'h0100, 16'h0010, 2'd1); step_and_check();
    // R2 execute-only read, readable read, fetch from data
    access(2'd0, 1, 0, 0, 16'h0100, 16'h0010, 2'd0); step_and_check();
    access(2'd0, 1, 1, 0, 16'h0100, 16'h0010, 2'd0); step_and_check();
    access(2'd2, 0, 1, 0, 16'h0100, 16'h0010, 2'd0); step_and_check();
    // R3 write to read-only data
    access(2'd1, 0, 0, 0, 16'h0100, 16'h0010, 2'd0); step_and_check();
    // R4 limit edge: last byte equal to limit passes, one past faults
    access(2'd0, 0, 1, 0, 16'h0100, 16'h00FF, 2'd1); step_and_check();
    access(2'd0, 0, 1, 0, 16'h0100, 16'h0100, 2'd1); step_and_check();
    access(2'd1, 0, 1, 1, 16'h0100, 16'h0100, 2'd1); step_and_check();
    // R4 type beats limit even on the stack
    access(2'd1, 0, 0, 1, 16'h0010, 16'h0100, 2'd0); step_and_check();
    // R5 offset wrap
    access(2'd0, 0, 1, 0, 16'h0010, 16'hFFFF, 2'd1); step_and_check();
    chk("R5", {31'd0, fault}, 32'd0);
    // R6 / R7
    idle_inputs(); ins_valid = 1; ins_class = 2'd1; cpl = 2'd1; step_and_check();
    idle_inputs(); ins_valid = 1; ins_class = 2'd1; cpl = 2'd0; step_and_check();
    idle_inputs(); ins_valid = 1; ins_class = 2'd2; cpl = 2'd2;
    flags_cur = 16'h4000; step_and_check();
    idle_inputs(); ins_valid = 1; ins_class = 2'd2; cpl = 2'd3;
    flags_cur = 16'h4000; step_and_check();
    // R11 instruction fault with stack limit fault
    access(2'd0, 0, 1, 1, 16'h0000, 16'h0005, 2'd0);
    ins_valid = 1; ins_class = 2'd1; cpl = 2'd3; step_and_check();
    chk("R11", {24'd0, fault_vec}, 32'd13);
    // R8 / R9 flag filtering
    idle_inputs(); flag_upd = 1; cpl = 2'd3; flags_cur = 16'h2200;
    flags_new = 16'h45FF; step_and_check();
    chk("R9", {31'd0, fault}, 32'd0);
    idle_inputs(); flag_upd = 1; cpl = 2'd0; flags_cur = 16'h0000;
    flags_new = 16'hFFFF; step_and_check();
    idle_inputs(); flag_upd = 1; cpl = 2'd1; flags_cur = 16'h2000;
    flags_new = 16'h5E00; step_and_check();
    // R10 quiet cycle
    idle_inputs(); step_and_check();

    for (int i = 0; i < 3000; i++) begin
      acc_valid = 1'($urandom);
      acc_kind  = 2'($urandom);
      seg_code  = 1'($urandom);
      seg_rw    = 1'($urandom);
      seg_stack = 1'($urandom);
      seg_limit = 16'($urandom);
      acc_ofs   = ($urandom % 4 == 0) ? seg_limit - 16'($urandom % 3) : 16'($urandom);
      acc_span  = 2'($urandom);
      ins_valid = 1'($urandom);
      ins_class = 2'($urandom);
      cpl       = 2'($urandom);
      flags_cur = 16'($urandom);
      flag_upd  = 1'($urandom);
      flags_new = 16'($urandom);
      step_and_check();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule